// File: doc/BRIEF.md
# Outbound Address Translation Windows

This block turns a 32-bit local write address into a 34-bit fabric address and picks the header fields for the outgoing write request. It holds a parameterizable bank of translation windows. Each window is set up through a simple write-only register port. A window has a base, a compare mask carrying an enable flag, an offset, and a control word. The control word holds a destination identifier, a priority, a write packet type and the two top bits of the fabric address.

A lookup is started by raising `in_valid` with `in_addr`. Every enabled window clears the address bits that its mask leaves uncompared and checks the rest against its base. The lowest-numbered matching window supplies the result. One cycle later `res_valid` pulses, together with either `res_hit` and the translated address and header fields, or `res_miss` alone. On a miss the caller must not send a packet. Building and sending the packet happen outside this block.

Top module: `xw_translator`

## Requirements
- R1: After a synchronous reset, all window registers hold zero, so every window is disabled, and all result outputs are low.
- R2: A lookup presented with `in_valid` in one cycle produces `res_valid` high for exactly the next cycle. Back-to-back lookups give back-to-back results in the same order. With no lookup there is no result.
- R3: Let the compare mask be M = {mask[31:1], 0}. An enabled window matches when (in_addr AND M) equals (base AND M). Address bit 0 is therefore never compared.
- R4: A window whose enable flag (mask register bit 0) is clear never matches, even if its base compares equal.
- R5: On a hit, res_addr[31:0] = (offset AND M) OR (in_addr AND NOT M), and res_addr[33:32] = control bits [13:12] of the chosen window.
- R6: When several windows match, the one with the lowest index is chosen.
- R7: On a hit, res_dest = control[7:0] and res_prio = control[9:8]. res_wtype = control[11:10], with 0 meaning a posted write, 1 a write that asks for a response, and 2 a streaming write.
- R8: A stored write type code of 3 is reported as 0, the posted write.
- R9: When no window matches, `res_miss` is high and `res_hit` is low. res_addr, res_dest, res_prio, res_wtype and res_win are all zero.
- R10: A register write and a lookup in the same cycle do not interact: the lookup uses the values held before the write, and the write affects only later lookups.
- R11: `reg_addr` is {window index, select}, where the select is 2 bits: 0 base, 1 mask, 2 offset, 3 control. A write whose window index is at or beyond NWIN changes no window.
- R12: On a hit, `res_win` gives the index of the chosen window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | IDX_W+2 | Window index (upper bits) and register select (low 2 bits) |
| reg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Lookup request |
| in_addr | input | 32 | Local address to translate |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_hit | output | 1 | A window matched |
| res_miss | output | 1 | No window matched |
| res_addr | output | 34 | Translated fabric address |
| res_dest | output | 8 | Destination identifier |
| res_prio | output | 2 | Request priority |
| res_wtype | output | 2 | Write packet type (0 posted, 1 with response, 2 streaming) |
| res_win | output | IDX_W | Index of the matching window |

## Verification
On every cycle the assertions check:
- the one-cycle result timing, and that results stay quiet when idle;
- that hit and miss exclude each other;
- that a miss result carries only zeros;
- that a hit never reports type code 3 and always reports an index within range;
- that address bit 0 passes through unchanged.

Only the bench's scenarios can show the rest, since it depends on what was programmed:
- the match rule and the translated value;
- the priority order when windows overlap;
- the effect of the enable flag;
- the ordering of a write against a lookup in the same cycle;
- that out-of-range register writes are dropped.

// File: rtl/xw_pkg.sv
package xw_pkg;

  localparam int LOC_AW = 32;
  localparam int FAB_AW = 34;
  localparam int DEST_W = 8;

  // write packet kinds carried in control[11:10]
  typedef enum logic [1:0] {
    WT_POSTED = 2'd0,
    WT_ACKED  = 2'd1,
    WT_STREAM = 2'd2
  } wtype_e;

  // register select in the low two bits of reg_addr
  localparam logic [1:0] SEL_BASE = 2'd0;
  localparam logic [1:0] SEL_MASK = 2'd1;
  localparam logic [1:0] SEL_OFFS = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

  typedef struct packed {
    logic [LOC_AW-1:0] base;
    logic [LOC_AW-1:0] mask;
    logic [LOC_AW-1:0] offset;
    logic [LOC_AW-1:0] ctrl;
  } win_cfg_t;

  typedef struct packed {
    logic              hit;
    logic [FAB_AW-1:0] addr;
    logic [DEST_W-1:0] dest;
    logic [1:0]        prio;
    logic [1:0]        wtype;
  } win_res_t;

endpackage

// File: rtl/xw_regs.sv
module xw_regs
  import xw_pkg::*;
#(
  parameter int NWIN  = 6,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W+1:0] addr,
  input  logic [31:0]      wdata,
  output win_cfg_t         cfg [NWIN]
);

  logic [IDX_W-1:0] idx;
  logic [1:0]       sel;

  assign idx = addr[IDX_W+1:2];
  assign sel = addr[1:0];

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg[w] <= '0;
      end else if (we && idx == IDX_W'(w)) begin
        case (sel)
          SEL_BASE: cfg[w].base   <= wdata;
          SEL_MASK: cfg[w].mask   <= wdata;
          SEL_OFFS: cfg[w].offset <= wdata;
          default:  cfg[w].ctrl   <= wdata;
        endcase
      end
    end
  end

endmodule

// File: rtl/xw_match.sv
module xw_match
  import xw_pkg::*;
(
  input  win_cfg_t    cfg,
  input  logic [31:0] addr,
  output win_res_t    res
);

  logic [31:0] cmp_m;
  logic [1:0]  kind;

  assign cmp_m = {cfg.mask[31:1], 1'b0};
  assign kind  = cfg.ctrl[11:10];

  always_comb begin
    res.hit   = cfg.mask[0] && (((addr ^ cfg.base) & cmp_m) == 32'd0);
    res.addr  = {cfg.ctrl[13:12], (cfg.offset & cmp_m) | (addr & ~cmp_m)};
    res.dest  = cfg.ctrl[7:0];
    res.prio  = cfg.ctrl[9:8];
    res.wtype = (kind == 2'd3) ? WT_POSTED : kind;
  end

endmodule

// File: rtl/xw_pick.sv
module xw_pick
  import xw_pkg::*;
#(
  parameter int NWIN  = 6,
  parameter int IDX_W = 3
) (
  input  win_res_t         cand [NWIN],
  output win_res_t         sel,
  output logic [IDX_W-1:0] idx
);

  // walk from the top so the lowest matching index is the last assignment
  always_comb begin
    sel = '0;
    idx = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (cand[i].hit) begin
        sel = cand[i];
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/xw_translator.sv
module xw_translator
  import xw_pkg::*;
#(
  parameter  int NWIN  = 6,
  localparam int IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [IDX_W+1:0] reg_addr,
  input  logic [31:0]      reg_wdata,
  input  logic             in_valid,
  input  logic [31:0]      in_addr,
  output logic             res_valid,
  output logic             res_hit,
  output logic             res_miss,
  output logic [33:0]      res_addr,
  output logic [7:0]       res_dest,
  output logic [1:0]       res_prio,
  output logic [1:0]       res_wtype,
  output logic [IDX_W-1:0] res_win
);

  win_cfg_t         cfg  [NWIN];
  win_res_t         cand [NWIN];
  win_res_t         best;
  logic [IDX_W-1:0] best_idx;
  logic             take;

  xw_regs #(.NWIN(NWIN), .IDX_W(IDX_W)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (reg_we),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .cfg   (cfg)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_match
    xw_match u_match (
      .cfg  (cfg[w]),
      .addr (in_addr),
      .res  (cand[w])
    );
  end

  xw_pick #(.NWIN(NWIN), .IDX_W(IDX_W)) u_pick (
    .cand (cand),
    .sel  (best),
    .idx  (best_idx)
  );

  assign take = in_valid && best.hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_miss  <= 1'b0;
      res_addr  <= '0;
      res_dest  <= '0;
      res_prio  <= '0;
      res_wtype <= '0;
      res_win   <= '0;
    end else begin
      res_valid <= in_valid;
      res_hit   <= take;
      res_miss  <= in_valid && !best.hit;
      res_addr  <= take ? best.addr  : '0;
      res_dest  <= take ? best.dest  : '0;
      res_prio  <= take ? best.prio  : '0;
      res_wtype <= take ? best.wtype : '0;
      res_win   <= take ? best_idx   : '0;
    end
  end

endmodule

// File: rtl/xw_checker.sv
module xw_checker #(
  parameter int NWIN  = 6,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [31:0]      in_addr,
  input logic             res_valid,
  input logic             res_hit,
  input logic             res_miss,
  input logic [33:0]      res_addr,
  input logic [7:0]       res_dest,
  input logic [1:0]       res_prio,
  input logic [1:0]       res_wtype,
  input logic [IDX_W-1:0] res_win
);

  initial begin
    p_win_count_r11: assert (NWIN >= 1 && NWIN <= 16);
  end

  // R1: the cycle after reset shows no result
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!res_valid && !res_hit && !res_miss));

  // R2: one-cycle latency
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (res_valid == $past(in_valid)));

  // R2: no flags without a result
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (!res_hit && !res_miss));

  // R9: a result is exactly one of hit or miss
  p_hit_xor_miss_r9: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_hit ^ res_miss));

  // R9: miss carries zeros
  p_miss_zero_r9: assert property (@(posedge clk) disable iff (rst)
    res_miss |-> (res_addr == '0 && res_dest == '0 && res_prio == '0 &&
                  res_wtype == '0 && res_win == '0));

  // R8: code 3 never leaves the block
  p_wtype_legal_r8: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> (res_wtype != 2'd3));

  // R12: reported window exists
  p_win_range_r12: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> (int'(res_win) < NWIN));

  // R5: bit 0 is never masked, so it passes straight through
  p_lsb_pass_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && res_hit) |-> (res_addr[0] == $past(in_addr[0])));

endmodule

bind xw_translator xw_checker #(.NWIN(NWIN), .IDX_W(IDX_W)) u_xw_checker (.*);

// File: tb/test_xw_translator.sv
module test_xw_translator;

  localparam int NW  = 6;
  localparam int IDX = 3;

  typedef struct packed {
    logic        hit;
    logic [33:0] addr;
    logic [7:0]  dest;
    logic [1:0]  prio;
    logic [1:0]  wtype;
    logic [2:0]  win;
  } exp_t;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           reg_we = 1'b0;
  logic [IDX+1:0] reg_addr = '0;
  logic [31:0]    reg_wdata = '0;
  logic           in_valid = 1'b0;
  logic [31:0]    in_addr = '0;
  logic           res_valid, res_hit, res_miss;
  logic [33:0]    res_addr;
  logic [7:0]     res_dest;
  logic [1:0]     res_prio, res_wtype;
  logic [IDX-1:0] res_win;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [31:0] m_base [NW];
  logic [31:0] m_mask [NW];
  logic [31:0] m_offs [NW];
  logic [31:0] m_ctrl [NW];

  exp_t  exp_q [$];
  string tag_q [$];

  always #5 clk = ~clk;

  xw_translator #(.NWIN(NW)) i_xw_translator (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .in_valid(in_valid), .in_addr(in_addr),
    .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
    .res_addr(res_addr), .res_dest(res_dest), .res_prio(res_prio),
    .res_wtype(res_wtype), .res_win(res_win)
  );

  function automatic exp_t model(logic [31:0] a);
    exp_t e = '0;
    for (int i = 0; i < NW; i++) begin
      logic [31:0] m = {m_mask[i][31:1], 1'b0};
      if (!e.hit && m_mask[i][0] && ((a & m) == (m_base[i] & m))) begin
        e.hit   = 1'b1;
        e.addr  = {m_ctrl[i][13:12], (m_offs[i] & m) | (a & ~m)};
        e.dest  = m_ctrl[i][7:0];
        e.prio  = m_ctrl[i][9:8];
        e.wtype = (m_ctrl[i][11:10] == 2'd3) ? 2'd0 : m_ctrl[i][11:10];
        e.win   = 3'(i);
      end
    end
    return e;
  endfunction

  function automatic void model_wr(int w, int sel, logic [31:0] d);
    if (w < NW) begin
      case (sel)
        0: m_base[w] = d;
        1: m_mask[w] = d;
        2: m_offs[w] = d;
        default: m_ctrl[w] = d;
      endcase
    end
  endfunction

  task automatic wr(int w, int sel, logic [31:0] d);
    @(negedge clk);
    in_valid  = 1'b0;
    reg_we    = 1'b1;
    reg_addr  = {w[2:0], sel[1:0]};
    reg_wdata = d;
    model_wr(w, sel, d);
  endtask

  task automatic look(logic [31:0] a, string tag);
    @(negedge clk);
    exp_q.push_back(model(a));
    tag_q.push_back(tag);
    reg_we   = 1'b0;
    in_valid = 1'b1;
    in_addr  = a;
  endtask

  // write and lookup in the same cycle: lookup sees old values (R10)
  task automatic wr_look(int w, int sel, logic [31:0] d, logic [31:0] a, string tag);
    @(negedge clk);
    exp_q.push_back(model(a));
    tag_q.push_back(tag);
    model_wr(w, sel, d);
    reg_we    = 1'b1;
    reg_addr  = {w[2:0], sel[1:0]};
    reg_wdata = d;
    in_valid  = 1'b1;
    in_addr   = a;
  endtask

  task automatic idle();
    @(negedge clk);
    reg_we   = 1'b0;
    in_valid = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      exp_t e;
      exp_t g;
      string t;
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R2: result with no pending lookup, actual valid=1 expected valid=0");
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        g = '{hit: res_hit, addr: res_addr, dest: res_dest, prio: res_prio,
              wtype: res_wtype, win: res_win};
        if (g !== e || res_miss !== !e.hit) begin
          bad++;
          $display("FAIL %s: actual hit=%0b miss=%0b addr=%h dest=%h prio=%0d wt=%0d win=%0d expected hit=%0b addr=%h dest=%h prio=%0d wt=%0d win=%0d",
                   t, res_hit, res_miss, res_addr, res_dest, res_prio, res_wtype, res_win,
                   e.hit, e.addr, e.dest, e.prio, e.wtype, e.win);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < NW; i++) begin
      m_base[i] = '0; m_mask[i] = '0; m_offs[i] = '0; m_ctrl[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    total++;
    if (res_valid !== 1'b0 || res_hit !== 1'b0 || res_miss !== 1'b0 || res_addr !== '0) begin
      bad++;
      $display("FAIL R1: reset outputs actual v=%0b h=%0b m=%0b a=%h expected all zero",
               res_valid, res_hit, res_miss, res_addr);
    end
    look(32'h1234_5678, "R1 all windows disabled after reset");
    idle();

    // window 0: top nibble compare, enabled
    wr(0, 0, 32'h8000_0000);
    wr(0, 1, 32'hF000_0001);
    wr(0, 2, 32'h3000_0000);
    wr(0, 3, 32'h0000_265A);
    look(32'h8ABC_DEF1, "R3 R5 R7 R12 window 0 hit");
    look(32'h7FFF_FFFF, "R9 miss below window");
    look(32'h9000_0000, "R9 miss above window");
    idle();

    // window 1 programmed but disabled
    wr(1, 0, 32'h4000_0000);
    wr(1, 1, 32'hF000_0000);
    wr(1, 3, 32'h0000_1433);
    look(32'h4000_0010, "R4 disabled window ignored");
    idle();

    // window 2 overlaps window 0, type code 3
    wr(2, 0, 32'h8000_0000);
    wr(2, 1, 32'hFF00_0001);
    wr(2, 2, 32'h0100_0000);
    wr(2, 3, 32'h0000_1CC1);
    look(32'h8012_3456, "R6 lowest index wins");
    wr(0, 1, 32'hF000_0000);
    look(32'h8012_3456, "R6 R8 R12 window 2 after window 0 disabled");
    idle();

    // same-cycle write and lookup
    wr_look(0, 1, 32'hF000_0001, 32'h8055_0002, "R10 lookup uses old mask");
    look(32'h8055_0002, "R10 later lookup sees new mask");
    wr_look(0, 3, 32'h0000_0811, 32'h8000_0004, "R10 lookup uses old control");
    look(32'h8000_0004, "R10 R7 later lookup sees new control");
    idle();

    // out-of-range index writes must not alias onto any window
    wr(6, 1, 32'h0000_0001);
    wr(7, 1, 32'h0000_0001);
    wr(6, 3, 32'h0000_0000);
    wr(7, 0, 32'h1234_5678);
    look(32'h1234_5678, "R11 out-of-range writes dropped");
    look(32'h8000_0004, "R11 window 0 unchanged");
    idle();

    // window 3: full compare, exact match, back-to-back burst
    wr(3, 0, 32'h0000_1000);
    wr(3, 1, 32'hFFFF_FFFF);
    wr(3, 2, 32'hABCD_EF00);
    wr(3, 3, 32'h0000_3B7E);
    look(32'h0000_1001, "R2 R3 exact match bit 0 passes");
    look(32'h0000_1000, "R2 R3 R5 exact match");
    look(32'h0000_1002, "R2 R9 bit 1 differs");
    look(32'hC000_0000, "R2 R9 no window");
    idle();

    // window 5: compares nothing, catches everything left
    wr(5, 1, 32'h0000_0001);
    wr(5, 2, 32'hFFFF_FFFF);
    wr(5, 3, 32'h0000_25FF);
    look(32'hC000_0000, "R3 R5 R12 catch-all window");
    look(32'h0000_1000, "R6 window 3 beats catch-all");
    idle();
    idle();

    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R2: results missing, actual pending=%0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R2: watchdog expired, actual running expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule